// File: doc/BRIEF.md
# Preamble and Start-Delimiter Frame Synchroniser

This block takes one received frame of hard-decision symbols (one sign bit per symbol) and finds where the physical-layer header begins. It works in three passes over a stored copy of the frame. The first pass slides the known preamble symbol pattern over every allowed start position. It keeps the position with the strongest agreement, counted either way round, so a carrier phase flip of 180 degrees does no harm. The second pass demodulates differentially: each bit is the XOR of two neighbouring symbols. It checks that the scrambled preamble bits sit exactly at the coarse position. Only if they do not does it search a small window around that position for the best bit match. The third pass descrambles the stream and looks for the 16-bit start delimiter right after the preamble. Only when the delimiter is not there does it search the same small window again.

A frame is written one symbol per cycle, and a start strobe marks its first symbol. Searching begins on its own once the frame is full. The block then raises a one-cycle completion pulse with a found flag, the start offset of the preamble within the frame, and a code for the pass that fixed the offset.

Top module: `preamble_sync`

## Requirements
- R1: A frame is FRAME_LEN = MAX_OFF + 2*WIN + 144 symbols (192 by default). The symbol sampled with `frame_start` and `sym_valid` both high is index 0. Valid symbols before any start strobe are ignored, and a new start strobe during filling restarts the frame at index 0.
- R2: While `busy` is high, symbols and start strobes are ignored. `busy` rises the cycle after a frame is full and falls in the same cycle that `done` rises.
- R3: The coarse offset is the position o in 1..MAX_OFF with the largest |agree - disagree| between frame symbols o..o+127 and the reference symbols. Ties go to the smaller o. The reference symbols are Q[k] = Q[k-1] xor P[k], with Q[-1] = 0. P[k] is the scrambled preamble: 128 ones fed through c[k] = 1 xor c[k-4] xor c[k-7], where c[-m] = bit m-1 of the seed 7'h5B. Inverting every symbol leaves the offset unchanged.
- R4: Demodulated bit d[i] = s[i] xor s[i-1]. If d[o+k] equals P[k] for all 128 k at the coarse offset, no bit refinement runs. If the delimiter is also exact, the stage code is 1.
- R5: Otherwise the bit pass scores every o within ±WIN (default 4) of the coarse offset by the count of d[o+k] equal to P[k]. Positions outside 1..MAX_OFF+2*WIN are skipped. The best score wins, ties go to the smaller o, and the stage code becomes 2.
- R6: The descrambled bit is b[i] = d[i] xor d[i-4] xor d[i-7]. The delimiter check compares b[o+128+j], j = 0..15, with bit j of 16'hF3A0 (least significant bit first). An exact match keeps the offset and the stage code.
- R7: Otherwise the delimiter pass scores every valid o within ±WIN of the current offset. If the best score (ties to the smaller o) is at least THRESH (default 14), the frame is found at that o with stage code 3.
- R8: If no delimiter score reaches THRESH, `found` is 0 and the stage code is 0.
- R9: `done` is a single-cycle pulse no more than MAX_OFF + 4*WIN + 6 clock edges after the edge that takes the last symbol. `found`, `sync_offset` and `settle_stage` change only together with `done` and hold until the next one.
- R10: After reset, `busy`, `done`, `found`, `sync_offset` and `settle_stage` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | A symbol is present on `sym_bit` |
| sym_bit | input | 1 | Symbol sign bit |
| frame_start | input | 1 | Marks the first symbol of a frame |
| busy | output | 1 | Search in progress; input ignored |
| done | output | 1 | One-cycle result pulse |
| found | output | 1 | Delimiter located |
| sync_offset | output | OFF_W ($clog2(MAX_OFF+2*WIN+1), 6 by default) | Preamble start index within the frame |
| settle_stage | output | 2 | 0 none, 1 coarse, 2 bit refinement, 3 delimiter refinement |

## Verification
The bench targets preambles whose start sits at the first and the last allowed position. A design with an off-by-one in the window clamp there would report a position the frame cannot hold, or miss the true start. Single-symbol faults placed in the preamble and in the last delimiter symbol must trigger exactly one refinement and name the right stage. A design that refines unconditionally, or never, gets the stage code wrong. A phase-inverted frame catches a correlator that scores only positive agreement. A complemented delimiter must end as not-found rather than settling on a weak neighbour. Junk symbols before the start strobe, a restarted partial frame and a second frame pushed during the search must all leave the result untouched. A design that writes the buffer at those times reports a different offset.

// File: rtl/psync_pkg.sv
package psync_pkg;

    localparam int PRE_LEN = 128;
    localparam int SFD_LEN = 16;
    localparam logic [SFD_LEN-1:0] SFD_WORD = 16'hF3A0;
    localparam logic [6:0] SCR_SEED = 7'h5B;
    localparam int SCORE_W = $clog2(PRE_LEN + 1);

    typedef enum logic [1:0] {
        ST_NONE   = 2'd0,
        ST_COARSE = 2'd1,
        ST_BITS   = 2'd2,
        ST_DELIM  = 2'd3
    } settle_e;

    typedef enum logic [2:0] {
        S_IDLE, S_COARSE, S_CHK2, S_REF2, S_CHK3, S_REF3, S_FIN
    } search_e;

    // scrambled all-ones preamble; hist[m-1] holds the bit m places back
    function automatic logic [PRE_LEN-1:0] scrambled_preamble();
        logic [6:0] hist;
        logic [PRE_LEN-1:0] r;
        logic c;
        hist = SCR_SEED;
        for (int k = 0; k < PRE_LEN; k++) begin
            c = 1'b1 ^ hist[3] ^ hist[6];
            r[k] = c;
            hist = {hist[5:0], c};
        end
        return r;
    endfunction

    // differential encoding from a zero reference symbol
    function automatic logic [PRE_LEN-1:0] diff_encode(input logic [PRE_LEN-1:0] bits);
        logic [PRE_LEN-1:0] r;
        logic prev;
        prev = 1'b0;
        for (int k = 0; k < PRE_LEN; k++) begin
            r[k] = prev ^ bits[k];
            prev = r[k];
        end
        return r;
    endfunction

    function automatic logic [SCORE_W-1:0] ones_pre(input logic [PRE_LEN-1:0] v);
        logic [SCORE_W-1:0] n;
        n = '0;
        for (int k = 0; k < PRE_LEN; k++) n = n + SCORE_W'(v[k]);
        return n;
    endfunction

    function automatic logic [SCORE_W-1:0] ones_sfd(input logic [SFD_LEN-1:0] v);
        logic [SCORE_W-1:0] n;
        n = '0;
        for (int k = 0; k < SFD_LEN; k++) n = n + SCORE_W'(v[k]);
        return n;
    endfunction

endpackage

// File: rtl/psync_capture.sv
module psync_capture #(
    parameter int FRAME_LEN = 192
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  logic                 sym_valid,
    input  logic                 sym_bit,
    input  logic                 frame_start,
    output logic [FRAME_LEN-1:0] frame,
    output logic                 full
);
    localparam int IW = $clog2(FRAME_LEN);
    localparam logic [IW-1:0] LAST = IW'(FRAME_LEN - 1);

    logic          filling;
    logic [IW-1:0] idx;
    logic [IW-1:0] wr_idx;
    logic          take;

    assign take   = accept && sym_valid && (frame_start || filling);
    assign wr_idx = frame_start ? '0 : idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            filling <= 1'b0;
            idx     <= '0;
            full    <= 1'b0;
            frame   <= '0;
        end else begin
            full <= 1'b0;
            if (take) begin
                frame[wr_idx] <= sym_bit;
                if (wr_idx == LAST) begin
                    filling <= 1'b0;
                    idx     <= '0;
                    full    <= 1'b1;
                end else begin
                    filling <= 1'b1;
                    idx     <= wr_idx + IW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/psync_stream.sv
module psync_stream #(
    parameter int FRAME_LEN = 192
) (
    input  logic [FRAME_LEN-1:0] frame,
    output logic [FRAME_LEN-1:0] demod,
    output logic [FRAME_LEN-1:0] descr
);
    assign demod[0] = 1'b0;
    for (genvar i = 1; i < FRAME_LEN; i++) begin : g_demod
        assign demod[i] = frame[i] ^ frame[i-1];
    end

    for (genvar i = 0; i < FRAME_LEN; i++) begin : g_descr
        if (i >= 7) begin : g_tap
            assign descr[i] = demod[i] ^ demod[i-4] ^ demod[i-7];
        end else begin : g_head
            assign descr[i] = demod[i];
        end
    end
endmodule

// File: rtl/psync_search.sv
module psync_search
    import psync_pkg::*;
#(
    parameter int MAX_OFF   = 40,
    parameter int WIN       = 4,
    parameter int THRESH    = 14,
    parameter int FRAME_LEN = 192,
    parameter int OFF_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [FRAME_LEN-1:0] sym_frame,
    input  logic [FRAME_LEN-1:0] demod,
    input  logic [FRAME_LEN-1:0] descr,
    output logic                 busy,
    output logic                 done,
    output logic                 found,
    output logic [OFF_W-1:0]     offset,
    output settle_e              stage
);
    localparam int MAXPOS = MAX_OFF + 2 * WIN;
    localparam int CW = OFF_W + 2;
    localparam logic [PRE_LEN-1:0] PRE_BITS = scrambled_preamble();
    localparam logic [PRE_LEN-1:0] PRE_SYMS = diff_encode(PRE_BITS);
    localparam logic [SCORE_W-1:0] HALF = SCORE_W'(PRE_LEN / 2);

    search_e              state;
    logic signed [CW-1:0] cand;
    logic signed [CW-1:0] center;
    logic [OFF_W-1:0]     cur_off;
    logic [OFF_W-1:0]     best_off;
    logic [SCORE_W-1:0]   best_score;
    logic                 have;
    settle_e              stage_r;
    logic                 found_r;

    logic                 cand_ok;
    logic [OFF_W-1:0]     shamt;
    logic [FRAME_LEN-1:0] sym_sh, dem_sh, des_sh;
    logic [SCORE_W-1:0]   agree1, coarse_score, bits_score, delim_score, score;
    logic                 better;
    logic [OFF_W-1:0]     nxt_off;
    logic [SCORE_W-1:0]   nxt_score;

    assign center  = $signed({2'b00, cur_off});
    assign cand_ok = (cand >= CW'(1)) && (cand <= CW'(MAXPOS));
    assign shamt   = cand_ok ? cand[OFF_W-1:0] : '0;

    assign sym_sh = sym_frame >> shamt;
    assign dem_sh = demod >> shamt;
    assign des_sh = descr >> (int'(shamt) + PRE_LEN);

    assign agree1       = ones_pre(~(sym_sh[PRE_LEN-1:0] ^ PRE_SYMS));
    assign coarse_score = (agree1 >= HALF) ? ((agree1 - HALF) << 1) : ((HALF - agree1) << 1);
    assign bits_score   = ones_pre(~(dem_sh[PRE_LEN-1:0] ^ PRE_BITS));
    assign delim_score  = ones_sfd(~(des_sh[SFD_LEN-1:0] ^ SFD_WORD));

    always_comb begin
        case (state)
            S_COARSE:       score = coarse_score;
            S_CHK2, S_REF2: score = bits_score;
            default:        score = delim_score;
        endcase
    end

    assign better    = cand_ok && (!have || (score > best_score));
    assign nxt_off   = better ? shamt : best_off;
    assign nxt_score = better ? score : best_score;
    assign busy      = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            cand       <= '0;
            cur_off    <= '0;
            best_off   <= '0;
            best_score <= '0;
            have       <= 1'b0;
            stage_r    <= ST_NONE;
            found_r    <= 1'b0;
            done       <= 1'b0;
            found      <= 1'b0;
            offset     <= '0;
            stage      <= ST_NONE;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        cand    <= CW'(1);
                        have    <= 1'b0;
                        stage_r <= ST_COARSE;
                        found_r <= 1'b0;
                        state   <= S_COARSE;
                    end
                end
                S_COARSE: begin
                    best_off   <= nxt_off;
                    best_score <= nxt_score;
                    have       <= have | better;
                    if (cand == CW'(MAX_OFF)) begin
                        cur_off <= nxt_off;
                        cand    <= $signed({2'b00, nxt_off});
                        state   <= S_CHK2;
                    end else begin
                        cand <= cand + CW'(1);
                    end
                end
                S_CHK2: begin
                    if (score == SCORE_W'(PRE_LEN)) begin
                        state <= S_CHK3;
                    end else begin
                        cand  <= center - CW'(WIN);
                        have  <= 1'b0;
                        state <= S_REF2;
                    end
                end
                S_REF2: begin
                    best_off   <= nxt_off;
                    best_score <= nxt_score;
                    have       <= have | better;
                    if (cand == center + CW'(WIN)) begin
                        cur_off <= nxt_off;
                        cand    <= $signed({2'b00, nxt_off});
                        stage_r <= ST_BITS;
                        state   <= S_CHK3;
                    end else begin
                        cand <= cand + CW'(1);
                    end
                end
                S_CHK3: begin
                    if (score == SCORE_W'(SFD_LEN)) begin
                        found_r <= 1'b1;
                        state   <= S_FIN;
                    end else begin
                        cand  <= center - CW'(WIN);
                        have  <= 1'b0;
                        state <= S_REF3;
                    end
                end
                S_REF3: begin
                    best_off   <= nxt_off;
                    best_score <= nxt_score;
                    have       <= have | better;
                    if (cand == center + CW'(WIN)) begin
                        if (nxt_score >= SCORE_W'(THRESH)) begin
                            found_r <= 1'b1;
                            cur_off <= nxt_off;
                            stage_r <= ST_DELIM;
                        end else begin
                            found_r <= 1'b0;
                            stage_r <= ST_NONE;
                        end
                        state <= S_FIN;
                    end else begin
                        cand <= cand + CW'(1);
                    end
                end
                S_FIN: begin
                    done   <= 1'b1;
                    found  <= found_r;
                    offset <= cur_off;
                    stage  <= stage_r;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/preamble_sync.sv
module preamble_sync
    import psync_pkg::*;
#(
    parameter int MAX_OFF = 40,
    parameter int WIN     = 4,
    parameter int THRESH  = 14,
    localparam int MAXPOS    = MAX_OFF + 2 * WIN,
    localparam int FRAME_LEN = MAXPOS + PRE_LEN + SFD_LEN,
    localparam int OFF_W     = $clog2(MAXPOS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_valid,
    input  logic             sym_bit,
    input  logic             frame_start,
    output logic             busy,
    output logic             done,
    output logic             found,
    output logic [OFF_W-1:0] sync_offset,
    output logic [1:0]       settle_stage
);
    logic [FRAME_LEN-1:0] frame, demod, descr;
    logic                 full;
    logic                 srch_busy;
    settle_e              stage;

    assign busy         = full | srch_busy;
    assign settle_stage = stage;

    psync_capture #(.FRAME_LEN(FRAME_LEN)) u_capture (
        .clk(clk), .rst(rst), .accept(!busy), .sym_valid(sym_valid),
        .sym_bit(sym_bit), .frame_start(frame_start), .frame(frame), .full(full)
    );

    psync_stream #(.FRAME_LEN(FRAME_LEN)) u_stream (
        .frame(frame), .demod(demod), .descr(descr)
    );

    psync_search #(
        .MAX_OFF(MAX_OFF), .WIN(WIN), .THRESH(THRESH),
        .FRAME_LEN(FRAME_LEN), .OFF_W(OFF_W)
    ) u_search (
        .clk(clk), .rst(rst), .start(full), .sym_frame(frame), .demod(demod),
        .descr(descr), .busy(srch_busy), .done(done), .found(found),
        .offset(sync_offset), .stage(stage)
    );
endmodule

// File: rtl/psync_checker.sv
module psync_checker #(
    parameter int MAX_OFF = 40,
    parameter int WIN     = 4,
    localparam int MAXPOS = MAX_OFF + 2 * WIN,
    localparam int OFF_W  = $clog2(MAXPOS + 1),
    localparam int LIMIT  = MAX_OFF + 4 * WIN + 8
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             found,
    input logic [OFF_W-1:0] sync_offset,
    input logic [1:0]       settle_stage
);
    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= 0;
        else              busy_cnt <= busy_cnt + 1;
    end

    // R9: result strobe lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R9: results move only with the strobe
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(sync_offset) && $stable(found) && $stable(settle_stage)));
    // R9: bounded search time
    p_bound_r9: assert property (@(posedge clk) disable iff (rst) busy_cnt <= LIMIT);
    // R2: busy ends exactly at the result
    p_busy_end_r2: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
    // R7: a located frame names a settling pass
    p_found_code_r7: assert property (@(posedge clk) disable iff (rst)
        (done && found) |-> (settle_stage != 2'd0));
    // R8: a miss reports code 0
    p_miss_code_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !found) |-> (settle_stage == 2'd0));
    // R3: reported offset lies inside the searchable span
    p_offset_range_r3: assert property (@(posedge clk) disable iff (rst)
        (done && found) |-> (sync_offset >= OFF_W'(1) && sync_offset <= OFF_W'(MAXPOS)));
endmodule

bind preamble_sync psync_checker #(.MAX_OFF(MAX_OFF), .WIN(WIN)) u_psync_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .found(found),
    .sync_offset(sync_offset), .settle_stage(settle_stage)
);

// File: tb/preamble_sync_bench.sv
`timescale 1ns/1ps
module preamble_sync_bench;
    localparam int MAX_OFF = 40;
    localparam int WIN     = 4;
    localparam int THRESH  = 14;
    localparam int PRE     = 128;
    localparam int SFDN    = 16;
    localparam int MAXPOS  = MAX_OFF + 2 * WIN;
    localparam int FLEN    = MAXPOS + PRE + SFDN;
    localparam int OW      = $clog2(MAXPOS + 1);
    localparam int LAT_MAX = MAX_OFF + 4 * WIN + 6;
    localparam logic [15:0] DELIM = 16'hF3A0;
    localparam logic [6:0]  SEED  = 7'h5B;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_valid = 1'b0, sym_bit = 1'b0, frame_start = 1'b0;
    logic busy, done, found;
    logic [OW-1:0] sync_offset;
    logic [1:0] settle_stage;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    bit fr[FLEN];
    bit pbits[PRE + SFDN];
    bit qsym[PRE];
    bit dm[FLEN];
    bit bm[FLEN];

    always #2.5 clk = ~clk;

    preamble_sync #(.MAX_OFF(MAX_OFF), .WIN(WIN), .THRESH(THRESH)) u_preamble_sync (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_bit(sym_bit),
        .frame_start(frame_start), .busy(busy), .done(done), .found(found),
        .sync_offset(sync_offset), .settle_stage(settle_stage)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scrambled preamble then scrambled delimiter, and reference symbols
    task automatic build_refs();
        bit cc[PRE + SFDN + 7];
        bit din;
        for (int m = 1; m <= 7; m++) cc[7 - m] = SEED[m - 1];
        for (int k = 0; k < PRE + SFDN; k++) begin
            din = (k < PRE) ? 1'b1 : DELIM[k - PRE];
            cc[k + 7] = din ^ cc[k + 3] ^ cc[k];
            pbits[k] = cc[k + 7];
        end
        for (int k = 0; k < PRE; k++) qsym[k] = ((k == 0) ? 1'b0 : qsym[k - 1]) ^ pbits[k];
    endtask

    task automatic build_frame(input int tau, input bit inv);
        for (int i = 0; i < FLEN; i++) fr[i] = 1'($urandom);
        for (int k = 0; k < PRE + SFDN; k++) fr[tau + k] = fr[tau + k - 1] ^ pbits[k];
        if (inv) for (int i = 0; i < FLEN; i++) fr[i] = ~fr[i];
    endtask

    function automatic int s2(input int o);
        int a = 0;
        for (int k = 0; k < PRE; k++) if (dm[o + k] == pbits[k]) a++;
        return a;
    endfunction

    function automatic int s3(input int o);
        int a = 0;
        for (int j = 0; j < SFDN; j++) if (bm[o + PRE + j] == DELIM[j]) a++;
        return a;
    endfunction

    task automatic model(output bit f, output int off, output int st);
        int best, a, sc, c;
        best = -1; c = 1;
        for (int o = 1; o <= MAX_OFF; o++) begin
            a = 0;
            for (int k = 0; k < PRE; k++) if (fr[o + k] == qsym[k]) a++;
            sc = 2 * a - PRE;
            if (sc < 0) sc = -sc;
            if (sc > best) begin best = sc; c = o; end
        end
        dm[0] = 0;
        for (int i = 1; i < FLEN; i++) dm[i] = fr[i] ^ fr[i - 1];
        for (int i = 0; i < FLEN; i++) bm[i] = (i >= 7) ? (dm[i] ^ dm[i - 4] ^ dm[i - 7]) : dm[i];
        st = 1;
        if (s2(c) != PRE) begin
            best = -1;
            for (int o = c - WIN; o <= c + WIN; o++)
                if (o >= 1 && o <= MAXPOS && s2(o) > best) begin best = s2(o); off = o; end
            c = off; st = 2;
        end
        off = c; f = 1;
        if (s3(c) != SFDN) begin
            best = -1;
            for (int o = c - WIN; o <= c + WIN; o++)
                if (o >= 1 && o <= MAXPOS && s3(o) > best) begin best = s3(o); off = o; end
            if (best >= THRESH) st = 3;
            else begin f = 0; st = 0; off = c; end
        end
    endtask

    task automatic drive_frame();
        for (int i = 0; i < FLEN; i++) begin
            @(negedge clk);
            sym_valid = 1'b1; sym_bit = fr[i]; frame_start = (i == 0);
        end
        @(negedge clk);
        sym_valid = 1'b0; frame_start = 1'b0;
    endtask

    // waits for the result, checks latency, pulse width, hold and the model
    task automatic finish_frame(input string req);
        int lat = 0;
        bit mf; int mo, ms;
        int ho, hs;
        bit hf;
        while (!done && lat <= LAT_MAX + 20) begin @(negedge clk); lat++; end
        check(done == 1'b1 && lat <= LAT_MAX, "R9 latency", lat, LAT_MAX);
        model(mf, mo, ms);
        check(found == mf, {req, " found"}, found, mf);
        if (mf) check(int'(sync_offset) == mo, {req, " offset"}, sync_offset, mo);
        check(int'(settle_stage) == ms, {req, " stage"}, settle_stage, ms);
        hf = found; ho = sync_offset; hs = settle_stage;
        @(negedge clk);
        check(done == 1'b0, "R9 pulse", done, 0);
        repeat (3) @(negedge clk);
        check(found == hf && int'(sync_offset) == ho && int'(settle_stage) == hs,
              "R9 hold", sync_offset, ho);
    endtask

    task automatic expect_result(input string req, input bit f, input int o, input int s);
        check(found == f, {req, " found"}, found, f);
        if (f) check(int'(sync_offset) == o, {req, " offset"}, sync_offset, o);
        check(int'(settle_stage) == s, {req, " stage"}, settle_stage, s);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy == 0, "R10 busy", busy, 0);
        check(done == 0, "R10 done", done, 0);
        check(found == 0, "R10 found", found, 0);
        check(sync_offset == 0, "R10 offset", sync_offset, 0);
        check(settle_stage == 0, "R10 stage", settle_stage, 0);
    endtask

    task automatic t_clean(input int tau);
        build_frame(tau, 0);
        drive_frame();
        finish_frame("R4 clean");
        expect_result("R6 exact delimiter", 1, tau, 1);
    endtask

    task automatic t_inverted();
        build_frame(17, 1);
        drive_frame();
        finish_frame("R3 inverted");
        expect_result("R3 phase flip", 1, 17, 1);
    endtask

    task automatic t_pre_flip(input int tau);
        build_frame(tau, 0);
        fr[tau + 20] = ~fr[tau + 20];
        drive_frame();
        finish_frame("R5 bit refine");
        expect_result("R5 bit refine", 1, tau, 2);
    endtask

    task automatic t_sfd_flip(input int tau);
        build_frame(tau, 0);
        fr[tau + PRE + 15] = ~fr[tau + PRE + 15];
        drive_frame();
        finish_frame("R7 delimiter refine");
        expect_result("R7 delimiter refine", 1, tau, 3);
    endtask

    task automatic t_sfd_missing();
        build_frame(23, 0);
        for (int j = 0; j < SFDN; j++) fr[23 + PRE + j] = ~fr[23 + PRE + j];
        for (int j = 0; j < SFDN; j++) fr[23 + PRE + j] = fr[23 + PRE + j - 1] ^ pbits[PRE + j] ^ 1'b1;
        drive_frame();
        finish_frame("R8 no delimiter");
        check(found == 0, "R8 not found", found, 0);
        check(settle_stage == 0, "R8 code", settle_stage, 0);
    endtask

    task automatic t_lead_in();
        build_frame(9, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            sym_valid = 1'b1; sym_bit = 1'($urandom); frame_start = 1'b0;
        end
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            sym_valid = 1'b1; sym_bit = 1'($urandom); frame_start = (i == 0);
        end
        drive_frame();
        finish_frame("R1 lead-in");
        expect_result("R1 restart", 1, 9, 1);
    endtask

    task automatic t_busy();
        int seen_busy = 0;
        bit hold_fr[FLEN];
        build_frame(31, 0);
        hold_fr = fr;
        drive_frame();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (busy) seen_busy++;
            sym_valid = 1'b1; sym_bit = 1'($urandom); frame_start = (i % 8 == 0);
        end
        @(negedge clk);
        sym_valid = 1'b0; frame_start = 1'b0;
        check(seen_busy == 40, "R2 busy during search", seen_busy, 40);
        fr = hold_fr;
        finish_frame("R2 ignored while busy");
        expect_result("R2 ignored while busy", 1, 31, 1);
    endtask

    task automatic t_noisy(input int n);
        int tau;
        for (int r = 0; r < n; r++) begin
            tau = 1 + int'($urandom % MAX_OFF);
            build_frame(tau, r[0]);
            for (int e = 0; e < 12; e++) begin
                int p = 1 + int'($urandom % (FLEN - 1));
                fr[p] = ~fr[p];
            end
            drive_frame();
            finish_frame("R3 R5 R7 noisy");
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        build_refs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clean(12);
        t_clean(1);
        t_clean(MAX_OFF);
        t_inverted();
        t_pre_flip(20);
        t_pre_flip(1);
        t_pre_flip(MAX_OFF);
        t_sfd_flip(14);
        t_sfd_flip(MAX_OFF);
        t_sfd_missing();
        t_lead_in();
        t_busy();
        t_noisy(8);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule